// File: doc/BRIEF.md
# Per-Core Idle and Frequency-Change Sequencer

This block sits beside a cluster of processor cores. It gives each core a small bank of memory-mapped registers and one sequencer, and it carries out the hardware half of two low-power flows. Software arms a flow ahead of time. The flow starts only once the core signals wait-for-interrupt (WFI). The first flow takes the core down to power-off, and can also take the shared L2 down. It can wait for the core's snoop queue to drain, then waits a programmable delay, and then raises the core's power-off handshake. The second flow asks the clock logic for a frequency change and releases the core when the clock logic acknowledges it. Completion is recorded as a done event, which can also raise an interrupt.

Interrupts bound for a core can be masked by the block. Enabled IRQ, FIQ and debug inputs wake the core: they abort a power-down in progress or end a completed one. Power switches, clock generation and the cores themselves lie outside the block and appear only as single-wire handshakes. The register interface is a simple write strobe with a combinational read. Core c owns the bank at byte offset (c+1)×0x100. Two global registers sit at 0x004 and 0xF04.

Top module: `coreIdlePwrCtl`

## Requirements
- R1: After reset, the register at 0xF04 reads 0x00000064 and every other register reads 0. Per-core offsets are 0x04 (request), 0x08 (snoop handling), 0x0C (arming/mask), 0x20 (event) and 0x24 (boot address). Bits with no function read as 0. The request register keeps bits 16, 18 and 20. The arming register keeps bits 16, 17, 20, 21, 22, 24 and 25. Register 0x004 keeps bit 20.
- R2: A core's `irqOut` follows `irqIn` unless its arming-register bit 24 is set, and then it is 0. `fiqOut` behaves the same way under bit 25. The masks of one core have no effect on any other core.
- R3: A core starts no flow unless its arming bit 16 (idle wait) is set and its `coreWfi` is high, together with request bit 16 (power-down) or request bit 18 (frequency change).
- R4: Let D be bits 15:1 of register 0xF04. `pwrOff` rises D+1 clock edges after the first edge at which WFI, the arming bits and the snoop condition all hold.
- R5: When arming bit 17 (snoop wait) is set, the delay count does not start until `snoopEmpty` is high. The core stays powered for as long as `snoopEmpty` is low.
- R6: An IRQ, FIQ or debug input whose wake enable is set (arming bits 20, 21 and 22) ends a power-down at the next edge. The same edge clears request bits 16 and 20. An input whose enable is clear has no effect.
- R7: With request bit 18 armed and the core in WFI, `dfsGo` rises one edge later and holds until `dfsAck`. At the acknowledging edge, `dfsGo` falls, request bit 18 clears and event bit 1 (done) is set.
- R8: Event bit 1 clears when 0 is written to it; writing 1 to it leaves it unchanged. `dfsDoneIrq` equals the done bit gated by the inverse of event bit 17 (done-interrupt mask).
- R9: `l2PwrOff` is high only while register 0x004 bit 20 is set and every core is powered off with its request bit 20 set.
- R10: `snoopDetach` is high during the delay count and while powered off, unless snoop-handling bit 0 is set. In that case it stays low.
- R11: Each core's boot-address register (offset 0x24) is 32 bits wide, reads back as written and drives that core's slice of `bootAddr`.
- R12: When request bits 16 and 18 are both set, the frequency-change flow runs first and `pwrOff` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | ADDR_W | Register byte address |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Combinational read data for regAddr |
| coreWfi | input | NUM_CORES | Core is in wait-for-interrupt |
| snoopEmpty | input | NUM_CORES | Core's snoop queue is empty |
| irqIn | input | NUM_CORES | Raw IRQ per core |
| fiqIn | input | NUM_CORES | Raw FIQ per core |
| dbgIn | input | NUM_CORES | Debug wake request per core |
| dfsAck | input | NUM_CORES | Clock logic finished the frequency change |
| irqOut | output | NUM_CORES | IRQ toward core after masking |
| fiqOut | output | NUM_CORES | FIQ toward core after masking |
| pwrOff | output | NUM_CORES | Power-off handshake to the core's switch |
| l2PwrOff | output | 1 | Power-off request for shared L2 and fabric |
| dfsGo | output | NUM_CORES | Frequency-change request to clock logic |
| snoopDetach | output | NUM_CORES | Hardware detach of the core from snooping |
| dfsDoneIrq | output | NUM_CORES | Unmasked done interrupt |
| bootAddr | output | 32*NUM_CORES | Per-core boot redirect address |

## Verification
The bench builds the block with two cores, a 12-bit address and a 15-bit delay field. With two cores, the shared-L2 rule and cross-core isolation of the masks can be tested. The narrow delay register allows the delay to be swept over several small values, and each measured edge count is compared against D+2 edges from the WFI drive. Every combination of mask bits and IRQ/FIQ levels on core 0 is tried while core 1 is left unmasked.

// File: rtl/pmsPkg.sv
package pmsPkg;
  // per-core bank offsets (low byte of address)
  localparam logic [7:0] OFS_REQ  = 8'h04;
  localparam logic [7:0] OFS_SNP  = 8'h08;
  localparam logic [7:0] OFS_ARM  = 8'h0C;
  localparam logic [7:0] OFS_EVT  = 8'h20;
  localparam logic [7:0] OFS_BOOT = 8'h24;
  // global register offset within bank 0 and top bank
  localparam logic [7:0] OFS_GLB  = 8'h04;

  typedef struct packed {
    logic idleWait;
    logic snoopWait;
    logic irqWake;
    logic fiqWake;
    logic dbgWake;
    logic pwdReq;
    logic dfsReq;
    logic keepSnoop;
  } coreCfg_t;

  typedef struct packed {
    logic clrPwd;
    logic clrDfs;
    logic setDone;
  } coreStb_t;

  typedef enum logic [2:0] {ST_RUN, ST_SNOOP, ST_COUNT, ST_OFF, ST_DFS} seqState_t;
endpackage

// File: rtl/pmsRegFile.sv
module pmsRegFile import pmsPkg::*; #(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 12,
  parameter int DLY_W     = 15,
  parameter int DLY_RESET = 100
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   wrEn,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [31:0]            wrData,
  output logic [31:0]            rdData,
  input  coreStb_t               stb [NUM_CORES],
  output coreCfg_t               cfg [NUM_CORES],
  output logic [DLY_W-1:0]       dlyCount,
  input  logic [NUM_CORES-1:0]   irqIn,
  input  logic [NUM_CORES-1:0]   fiqIn,
  input  logic [NUM_CORES-1:0]   pwrOff,
  output logic [NUM_CORES-1:0]   irqOut,
  output logic [NUM_CORES-1:0]   fiqOut,
  output logic [NUM_CORES-1:0]   doneIrq,
  output logic                   l2PwrOff,
  output logic [NUM_CORES*32-1:0] bootAddr
);
  localparam int BANK_W = ADDR_W - 8;
  localparam logic [BANK_W-1:0] BANK_TOP = '1;
  localparam logic [DLY_W:0] DLY_INIT = DLY_RESET[DLY_W:0];

  logic [BANK_W-1:0] bank;
  logic [7:0] off;
  assign bank = addr[ADDR_W-1:8];
  assign off  = addr[7:0];

  logic fabricEn;
  logic [DLY_W:0] dlyReg;
  logic [NUM_CORES-1:0] offWithL2;
  logic [NUM_CORES*32-1:0] rdFlat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fabricEn <= 1'b0;
      dlyReg   <= DLY_INIT;
    end else if (wrEn && off == OFS_GLB) begin
      if (bank == '0)       fabricEn <= wrData[20];
      if (bank == BANK_TOP) dlyReg   <= wrData[DLY_W:0];
    end
  end
  assign dlyCount = dlyReg[DLY_W:1];

  for (genvar c = 0; c < NUM_CORES; c++) begin : gCore
    logic [2:0] reqR;   // {l2, dfs, pwd}
    logic [6:0] armR;   // {fiqMask, irqMask, dbgWake, fiqWake, irqWake, snoopWait, idleWait}
    logic keepR, doneR, doneMaskR;
    logic [31:0] bootR;
    logic hit;
    assign hit = wrEn && (bank == BANK_W'(c + 1));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        reqR <= '0; armR <= '0; keepR <= 1'b0;
        doneR <= 1'b0; doneMaskR <= 1'b0; bootR <= '0;
      end else begin
        if (hit && off == OFS_REQ)  reqR  <= {wrData[20], wrData[18], wrData[16]};
        if (hit && off == OFS_ARM)  armR  <= {wrData[25], wrData[24], wrData[22], wrData[21],
                                              wrData[20], wrData[17], wrData[16]};
        if (hit && off == OFS_SNP)  keepR <= wrData[0];
        if (hit && off == OFS_BOOT) bootR <= wrData;
        if (hit && off == OFS_EVT) begin
          doneMaskR <= wrData[17];
          doneR     <= doneR & wrData[1];
        end
        if (stb[c].clrPwd) begin
          reqR[0] <= 1'b0;
          reqR[2] <= 1'b0;
        end
        if (stb[c].clrDfs)  reqR[1] <= 1'b0;
        if (stb[c].setDone) doneR   <= 1'b1;
      end
    end

    assign cfg[c] = '{armR[0], armR[1], armR[2], armR[3], armR[4], reqR[0], reqR[1], keepR};
    assign irqOut[c]    = irqIn[c] & ~armR[5];
    assign fiqOut[c]    = fiqIn[c] & ~armR[6];
    assign doneIrq[c]   = doneR & ~doneMaskR;
    assign offWithL2[c] = pwrOff[c] & reqR[2];
    assign bootAddr[c*32 +: 32] = bootR;

    assign rdFlat[c*32 +: 32] =
      (off == OFS_REQ)  ? {11'b0, reqR[2], 1'b0, reqR[1], 1'b0, reqR[0], 16'b0} :
      (off == OFS_ARM)  ? {6'b0, armR[6], armR[5], 1'b0, armR[4], armR[3], armR[2],
                           2'b0, armR[1], armR[0], 16'b0} :
      (off == OFS_SNP)  ? {31'b0, keepR} :
      (off == OFS_EVT)  ? {14'b0, doneMaskR, 15'b0, doneR, 1'b0} :
      (off == OFS_BOOT) ? bootR : 32'b0;
  end

  assign l2PwrOff = fabricEn & (&offWithL2);

  always_comb begin
    rdData = '0;
    if (bank == '0 && off == OFS_GLB) rdData[20] = fabricEn;
    else if (bank == BANK_TOP && off == OFS_GLB) rdData[DLY_W:0] = dlyReg;
    for (int i = 0; i < NUM_CORES; i++)
      if (bank == BANK_W'(i + 1)) rdData = rdFlat[i*32 +: 32];
  end
endmodule

// File: rtl/pmsSeqCtl.sv
module pmsSeqCtl import pmsPkg::*; #(
  parameter int NUM_CORES = 2,
  parameter int DLY_W     = 15
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  coreCfg_t             cfg [NUM_CORES],
  input  logic [DLY_W-1:0]     dlyCount,
  input  logic [NUM_CORES-1:0] coreWfi,
  input  logic [NUM_CORES-1:0] snoopEmpty,
  input  logic [NUM_CORES-1:0] irqIn,
  input  logic [NUM_CORES-1:0] fiqIn,
  input  logic [NUM_CORES-1:0] dbgIn,
  input  logic [NUM_CORES-1:0] dfsAck,
  output coreStb_t             stb [NUM_CORES],
  output logic [NUM_CORES-1:0] pwrOff,
  output logic [NUM_CORES-1:0] dfsGo,
  output logic [NUM_CORES-1:0] snoopDetach
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : gSeq
    seqState_t st;
    logic [DLY_W-1:0] cnt;
    logic wake, downPath, ackNow;

    assign wake = (irqIn[c] & cfg[c].irqWake) | (fiqIn[c] & cfg[c].fiqWake) |
                  (dbgIn[c] & cfg[c].dbgWake);
    assign downPath = (st == ST_SNOOP) || (st == ST_COUNT) || (st == ST_OFF);
    assign ackNow   = (st == ST_DFS) && dfsAck[c];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        st  <= ST_RUN;
        cnt <= '0;
      end else begin
        case (st)
          ST_RUN:
            if (cfg[c].idleWait && coreWfi[c]) begin
              if (cfg[c].dfsReq) st <= ST_DFS;
              else if (cfg[c].pwdReq) begin
                if (cfg[c].snoopWait && !snoopEmpty[c]) st <= ST_SNOOP;
                else begin
                  st  <= ST_COUNT;
                  cnt <= dlyCount;
                end
              end
            end
          ST_SNOOP:
            if (wake) st <= ST_RUN;
            else if (snoopEmpty[c]) begin
              st  <= ST_COUNT;
              cnt <= dlyCount;
            end
          ST_COUNT:
            if (wake) st <= ST_RUN;
            else if (cnt == '0) st <= ST_OFF;
            else cnt <= cnt - 1'b1;
          ST_OFF:  if (wake) st <= ST_RUN;
          ST_DFS:  if (dfsAck[c]) st <= ST_RUN;
          default: st <= ST_RUN;
        endcase
      end
    end

    assign stb[c] = '{downPath && wake, ackNow, ackNow};
    assign pwrOff[c]      = (st == ST_OFF);
    assign dfsGo[c]       = (st == ST_DFS);
    assign snoopDetach[c] = ((st == ST_COUNT) || (st == ST_OFF)) && !cfg[c].keepSnoop;
  end
endmodule

// File: rtl/coreIdlePwrCtl.sv
module coreIdlePwrCtl import pmsPkg::*; #(
  parameter int NUM_CORES = 2,
  parameter int ADDR_W    = 12,
  parameter int DLY_W     = 15,
  parameter int DLY_RESET = 100
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    regWrEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [31:0]             regWrData,
  output logic [31:0]             regRdData,
  input  logic [NUM_CORES-1:0]    coreWfi,
  input  logic [NUM_CORES-1:0]    snoopEmpty,
  input  logic [NUM_CORES-1:0]    irqIn,
  input  logic [NUM_CORES-1:0]    fiqIn,
  input  logic [NUM_CORES-1:0]    dbgIn,
  input  logic [NUM_CORES-1:0]    dfsAck,
  output logic [NUM_CORES-1:0]    irqOut,
  output logic [NUM_CORES-1:0]    fiqOut,
  output logic [NUM_CORES-1:0]    pwrOff,
  output logic                    l2PwrOff,
  output logic [NUM_CORES-1:0]    dfsGo,
  output logic [NUM_CORES-1:0]    snoopDetach,
  output logic [NUM_CORES-1:0]    dfsDoneIrq,
  output logic [NUM_CORES*32-1:0] bootAddr
);
  coreCfg_t cfg [NUM_CORES];
  coreStb_t stb [NUM_CORES];
  logic [DLY_W-1:0] dlyCount;

  pmsRegFile #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W), .DLY_W(DLY_W), .DLY_RESET(DLY_RESET)) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .addr(regAddr), .wrData(regWrData),
    .rdData(regRdData), .stb(stb), .cfg(cfg), .dlyCount(dlyCount),
    .irqIn(irqIn), .fiqIn(fiqIn), .pwrOff(pwrOff), .irqOut(irqOut), .fiqOut(fiqOut),
    .doneIrq(dfsDoneIrq), .l2PwrOff(l2PwrOff), .bootAddr(bootAddr)
  );

  pmsSeqCtl #(.NUM_CORES(NUM_CORES), .DLY_W(DLY_W)) uSeq (
    .clk(clk), .rstN(rstN), .cfg(cfg), .dlyCount(dlyCount), .coreWfi(coreWfi),
    .snoopEmpty(snoopEmpty), .irqIn(irqIn), .fiqIn(fiqIn), .dbgIn(dbgIn), .dfsAck(dfsAck),
    .stb(stb), .pwrOff(pwrOff), .dfsGo(dfsGo), .snoopDetach(snoopDetach)
  );
endmodule

// File: rtl/pmsChecker.sv
module pmsChecker #(
  parameter int NUM_CORES = 2
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_CORES-1:0] irqIn,
  input logic [NUM_CORES-1:0] fiqIn,
  input logic [NUM_CORES-1:0] irqOut,
  input logic [NUM_CORES-1:0] fiqOut,
  input logic [NUM_CORES-1:0] pwrOff,
  input logic [NUM_CORES-1:0] dfsGo,
  input logic [NUM_CORES-1:0] dfsAck,
  input logic                 l2PwrOff
);
  for (genvar c = 0; c < NUM_CORES; c++) begin : gChk
    p_irq_block_r2: assert property (@(posedge clk) disable iff (!rstN) irqOut[c] |-> irqIn[c])
      else $error("irqOut high without irqIn");
    p_fiq_block_r2: assert property (@(posedge clk) disable iff (!rstN) fiqOut[c] |-> fiqIn[c])
      else $error("fiqOut high without fiqIn");
    p_dfs_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
      (dfsGo[c] && !dfsAck[c]) |=> dfsGo[c])
      else $error("dfsGo dropped before ack");
    p_dfs_end_r7: assert property (@(posedge clk) disable iff (!rstN)
      (dfsGo[c] && dfsAck[c]) |=> !dfsGo[c])
      else $error("dfsGo held after ack");
    p_exclusive_r12: assert property (@(posedge clk) disable iff (!rstN) !(pwrOff[c] && dfsGo[c]))
      else $error("power-off during frequency change");
  end

  p_l2_all_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    l2PwrOff |-> (pwrOff == '1))
    else $error("L2 off while a core is powered");
endmodule

bind coreIdlePwrCtl pmsChecker #(.NUM_CORES(NUM_CORES)) uChk (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .fiqIn(fiqIn), .irqOut(irqOut), .fiqOut(fiqOut),
  .pwrOff(pwrOff), .dfsGo(dfsGo), .dfsAck(dfsAck), .l2PwrOff(l2PwrOff)
);

// File: tb/sim_coreIdlePwrCtl.sv
module sim_coreIdlePwrCtl;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [NC-1:0] coreWfi = '0, snoopEmpty = '0, irqIn = '0, fiqIn = '0, dbgIn = '0, dfsAck = '0;
  logic [NC-1:0] irqOut, fiqOut, pwrOff, dfsGo, snoopDetach, dfsDoneIrq;
  logic l2PwrOff;
  logic [NC*32-1:0] bootAddr;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  coreIdlePwrCtl #(.NUM_CORES(NC), .ADDR_W(12), .DLY_W(15), .DLY_RESET(100)) u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(regRdData), .coreWfi(coreWfi), .snoopEmpty(snoopEmpty), .irqIn(irqIn),
    .fiqIn(fiqIn), .dbgIn(dbgIn), .dfsAck(dfsAck), .irqOut(irqOut), .fiqOut(fiqOut),
    .pwrOff(pwrOff), .l2PwrOff(l2PwrOff), .dfsGo(dfsGo), .snoopDetach(snoopDetach),
    .dfsDoneIrq(dfsDoneIrq), .bootAddr(bootAddr)
  );

  task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic chkReg(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    regAddr = a;
    #1 chk(req, $sformatf("reg %0h", a), regRdData, exp);
  endtask

  task automatic edgesUntilOff(input int core, output int n);
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(posedge clk); #1;
      n++;
      if (pwrOff[core]) break;
    end
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    int dl [5] = '{0, 1, 2, 5, 9};
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1 reset state and register layout
    chkReg("R1", 12'hF04, 32'h64);
    chkReg("R1", 12'h104, 32'h0);
    chkReg("R1", 12'h20C, 32'h0);
    chk("R1", "pwrOff reset", 32'(pwrOff), 32'h0);
    chk("R1", "dfsGo reset", 32'(dfsGo), 32'h0);
    wr(12'h104, 32'hFFFF_FFFF); chkReg("R1", 12'h104, 32'h0015_0000);
    wr(12'h10C, 32'hFFFF_FFFF); chkReg("R1", 12'h10C, 32'h0373_0000);
    wr(12'h108, 32'hFFFF_FFFF); chkReg("R1", 12'h108, 32'h1);
    wr(12'h120, 32'hFFFF_FFFF); chkReg("R1", 12'h120, 32'h0002_0000);
    wr(12'h004, 32'hFFFF_FFFF); chkReg("R1", 12'h004, 32'h0010_0000);
    chkReg("R1", 12'h204, 32'h0);
    wr(12'h104, 0); wr(12'h10C, 0); wr(12'h108, 0); wr(12'h120, 0); wr(12'h004, 0);

    // R11 boot address per core
    wr(12'h124, 32'hDEAD_BEEF); chkReg("R11", 12'h124, 32'hDEAD_BEEF);
    wr(12'h224, 32'h1234_5678);
    chk("R11", "bootAddr core0", bootAddr[31:0], 32'hDEAD_BEEF);
    chk("R11", "bootAddr core1", bootAddr[63:32], 32'h1234_5678);

    // R2 mask sweep on core 0, core 1 unmasked
    for (int m = 0; m < 4; m++) begin
      wr(12'h10C, 32'(m) << 24);
      for (int i = 0; i < 4; i++) begin
        @(negedge clk);
        irqIn = {i[0], i[0]}; fiqIn = {i[1], i[1]};
        #1;
        chk("R2", "irqOut0", 32'(irqOut[0]), 32'(i[0] & ~m[0]));
        chk("R2", "fiqOut0", 32'(fiqOut[0]), 32'(i[1] & ~m[1]));
        chk("R2", "irqOut1", 32'(irqOut[1]), 32'(i[0]));
        chk("R2", "fiqOut1", 32'(fiqOut[1]), 32'(i[1]));
      end
    end
    @(negedge clk) irqIn = '0; fiqIn = '0;
    wr(12'h10C, 0);

    // R3 no start without idle-wait arming, nor without a request
    wr(12'h F04, 0);
    wr(12'h104, 32'h0001_0000);
    @(negedge clk) coreWfi[0] = 1'b1;
    repeat (6) @(posedge clk); #1;
    chk("R3", "pwrOff without idle wait", 32'(pwrOff[0]), 32'h0);
    wr(12'h104, 0); wr(12'h10C, 32'h0001_0000);
    repeat (6) @(posedge clk); #1;
    chk("R3", "pwrOff without request", 32'(pwrOff[0]), 32'h0);
    chk("R3", "dfsGo without request", 32'(dfsGo[0]), 32'h0);
    @(negedge clk) coreWfi[0] = 1'b0;

    // R4 delay sweep, R6 IRQ wake, R10 detach default
    foreach (dl[k]) begin
      wr(12'hF04, 32'(dl[k]) << 1);
      wr(12'h10C, 32'h0011_0000);
      wr(12'h104, 32'h0001_0000);
      @(negedge clk) coreWfi[0] = 1'b1;
      edgesUntilOff(0, n);
      chk("R4", $sformatf("edges to pwrOff D=%0d", dl[k]), 32'(n), 32'(dl[k] + 2));
      chk("R10", "snoopDetach while off", 32'(snoopDetach[0]), 32'h1);
      @(negedge clk) irqIn[0] = 1'b1;
      @(posedge clk); #1;
      chk("R6", "pwrOff after irq wake", 32'(pwrOff[0]), 32'h0);
      chkReg("R6", 12'h104, 32'h0);
      @(negedge clk) irqIn[0] = 1'b0; coreWfi[0] = 1'b0;
    end

    // R5 snoop wait, R6 disabled wake ignored
    wr(12'hF04, 32'h4);
    wr(12'h10C, 32'h0013_0000);
    wr(12'h104, 32'h0001_0000);
    @(negedge clk) coreWfi[0] = 1'b1;
    repeat (8) @(posedge clk); #1;
    chk("R5", "pwrOff while snoop busy", 32'(pwrOff[0]), 32'h0);
    chk("R5", "no detach while snoop busy", 32'(snoopDetach[0]), 32'h0);
    @(negedge clk) snoopEmpty[0] = 1'b1;
    edgesUntilOff(0, n);
    chk("R5", "edges after snoop empty", 32'(n), 32'h4);
    @(negedge clk) fiqIn[0] = 1'b1;
    repeat (3) @(posedge clk); #1;
    chk("R6", "disabled fiq ignored", 32'(pwrOff[0]), 32'h1);
    chkReg("R6", 12'h104, 32'h0001_0000);
    @(negedge clk) irqIn[0] = 1'b1;
    @(posedge clk); #1;
    chk("R6", "irq ends power-off", 32'(pwrOff[0]), 32'h0);
    @(negedge clk) irqIn[0] = 1'b0; fiqIn[0] = 1'b0; coreWfi[0] = 1'b0; snoopEmpty[0] = 1'b0;

    // R10 detach suppressed, R6 debug wake clears both request bits
    wr(12'h108, 32'h1); wr(12'hF04, 0);
    wr(12'h10C, 32'h0041_0000);
    wr(12'h104, 32'h0011_0000);
    @(negedge clk) coreWfi[0] = 1'b1;
    edgesUntilOff(0, n);
    chk("R4", "edges D=0 second run", 32'(n), 32'h2);
    chk("R10", "detach suppressed", 32'(snoopDetach[0]), 32'h0);
    @(negedge clk) dbgIn[0] = 1'b1;
    @(posedge clk); #1;
    chk("R6", "debug wake", 32'(pwrOff[0]), 32'h0);
    chkReg("R6", 12'h104, 32'h0);
    @(negedge clk) dbgIn[0] = 1'b0; coreWfi[0] = 1'b0;
    wr(12'h108, 0);

    // R9 shared L2
    wr(12'h004, 32'h0010_0000);
    wr(12'h10C, 32'h0011_0000); wr(12'h20C, 32'h0011_0000);
    wr(12'h104, 32'h0011_0000); wr(12'h204, 32'h0001_0000);
    @(negedge clk) coreWfi = 2'b11;
    repeat (4) @(posedge clk); #1;
    chk("R9", "both off", 32'(pwrOff), 32'h3);
    chk("R9", "L2 stays up, core1 no L2 req", 32'(l2PwrOff), 32'h0);
    @(negedge clk) irqIn = 2'b11;
    @(posedge clk); #1;
    chk("R6", "both woken", 32'(pwrOff), 32'h0);
    @(negedge clk) irqIn = '0; coreWfi = '0;
    wr(12'h104, 32'h0011_0000); wr(12'h204, 32'h0011_0000);
    @(negedge clk) coreWfi = 2'b11;
    repeat (4) @(posedge clk); #1;
    chk("R9", "L2 off", 32'(l2PwrOff), 32'h1);
    wr(12'h004, 0);
    #1 chk("R9", "L2 up after fabric disable", 32'(l2PwrOff), 32'h0);
    chk("R9", "cores still off", 32'(pwrOff), 32'h3);
    @(negedge clk) irqIn = 2'b11;
    @(negedge clk) irqIn = '0; coreWfi = '0;
    wr(12'h10C, 0); wr(12'h20C, 0);

    // R7 frequency change
    wr(12'h10C, 32'h0001_0000);
    wr(12'h104, 32'h0004_0000);
    @(negedge clk) coreWfi[0] = 1'b1;
    @(posedge clk); #1;
    chk("R7", "dfsGo rises", 32'(dfsGo[0]), 32'h1);
    repeat (3) @(posedge clk); #1;
    chk("R7", "dfsGo held", 32'(dfsGo[0]), 32'h1);
    chkReg("R7", 12'h120, 32'h0);
    @(negedge clk) dfsAck[0] = 1'b1;
    @(posedge clk); #1;
    chk("R7", "dfsGo falls on ack", 32'(dfsGo[0]), 32'h0);
    @(negedge clk) dfsAck[0] = 1'b0; coreWfi[0] = 1'b0;
    chkReg("R7", 12'h104, 32'h0);
    chkReg("R7", 12'h120, 32'h2);
    chk("R8", "done irq unmasked", 32'(dfsDoneIrq[0]), 32'h1);

    // R8 done bit write-zero-to-clear and masking
    wr(12'h120, 32'h0002_0002); chkReg("R8", 12'h120, 32'h0002_0002);
    chk("R8", "done irq masked", 32'(dfsDoneIrq[0]), 32'h0);
    wr(12'h120, 32'h0002_0000); chkReg("R8", 12'h120, 32'h0002_0000);
    wr(12'h120, 32'h0000_0002); chkReg("R8", 12'h120, 32'h0);

    // R12 frequency change wins over power-down
    wr(12'h104, 32'h0005_0000);
    @(negedge clk) coreWfi[0] = 1'b1;
    @(posedge clk); #1;
    chk("R12", "dfsGo first", 32'(dfsGo[0]), 32'h1);
    chk("R12", "no power-off", 32'(pwrOff[0]), 32'h0);
    @(negedge clk) dfsAck[0] = 1'b1; coreWfi[0] = 1'b0;
    @(negedge clk) dfsAck[0] = 1'b0;
    chkReg("R12", 12'h104, 32'h0001_0000);
    wr(12'h104, 0); wr(12'h10C, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule